// File: doc/BRIEF.md
# Return-Address Stack with Selectable Overflow Handling

This block keeps the return addresses of a small processor core in a storage of its own, apart from program and data memory. Subroutine calls and interrupt entries of either priority push the return address onto the same stack. Returns pop it. Only the return address is kept; the target of a call is never stored. At most 31 levels are held. The pointer counts entries: 0 means empty and 31 means full.

The core and software see only the top entry, which is always visible on `tos_data`. Software may overwrite that entry in place, or drop it by lowering the pointer. Repeating that drop empties the stack one entry at a time, so its contents can be copied out. Two sticky flags record an overflow and an underflow.

A configuration input, changed only while reset is held, selects how faults are handled. In flag mode the fault is recorded and execution continues. In trap mode the block also raises a one-cycle trap request together with the reset vector address, for the program counter logic to act on.

Top module: `ret_stack_top`

## Requirements
- R1: After reset the pointer is 0, both flags are 0, `tos_data` is 0 and `trap_req` is 0.
- R2: A push on a stack holding fewer than 31 entries stores `push_addr` as the new top and raises the pointer by one. The new pointer and the new `tos_data` appear on the clock edge after the request.
- R3: A pop through `pop_req` or `sw_pop` on a non-empty stack lowers the pointer by one, and `tos_data` then shows the entry below the old top. While the stack is empty, `tos_data` reads 0.
- R4: The push that brings the pointer from 30 to 31 sets the overflow flag. The flag stays set until it is cleared or reset; a trap does not clear it.
- R5: In flag mode (`cfg_trap_mode` = 0), a push at pointer 31 replaces the top entry. The pointer stays at 31, the overflow flag is set and no trap is raised.
- R6: In trap mode (`cfg_trap_mode` = 1), the filling push and any push at pointer 31 raise `trap_req` for exactly one cycle. `trap_vec` is 0 at all times, and a push at pointer 31 leaves both the pointer and the stored entries unchanged.
- R7: A pop on an empty stack leaves the pointer at 0 and sets the underflow flag. It raises `trap_req` in trap mode only.
- R8: `tos_wr` replaces the top entry with `tos_wdata` and does not move the pointer. On an empty stack it is ignored, so a later push and pop show no trace of it.
- R9: `clr_ovf` and `clr_unf` clear their own flag. If a clear and a set of the same flag fall in the same cycle, the set wins.
- R10: Only one stack operation runs per cycle, in this priority order: push, then pop (`pop_req` or `sw_pop`), then top write. Requests of lower priority in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trap_mode | input | 1 | 0: flag only, 1: trap on fault; change only under reset |
| push_req | input | 1 | Push request from call or interrupt entry |
| push_addr | input | ADDR_W | Return address to push |
| pop_req | input | 1 | Pop request from a return |
| sw_pop | input | 1 | Software pointer decrement |
| tos_wr | input | 1 | Software write of the top entry |
| tos_wdata | input | ADDR_W | Data for the top entry write |
| clr_ovf | input | 1 | Clear the overflow flag |
| clr_unf | input | 1 | Clear the underflow flag |
| tos_data | output | ADDR_W | Current top entry, 0 when empty |
| sp | output | PTR_W | Entry count / stack pointer |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | ADDR_W | Trap target address (reset vector) |

## Verification
A wrong pointer or a wrong flag appears at the ports on the clock edge that follows the faulty operation. The pointer, the top entry, both flags and the trap pulse are all visible every cycle. A corrupted deeper entry stays hidden until the stack is popped down to it, so the bench drains the stack completely after each fill and compares every top value on the way down. Forwarding faults, where the top entry is written and read back at once, show up as a stale `tos_data` in the cycle right after a push or a top write.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_WR   = 2'd3
  } rs_op_e;

  // One operation per cycle: push beats pop beats top-entry write.
  function automatic rs_op_e pick_op(input logic push, input logic pop, input logic wr);
    if (push)     return OP_PUSH;
    else if (pop) return OP_POP;
    else if (wr)  return OP_WR;
    else          return OP_NONE;
  endfunction

endpackage

// File: rtl/rs_store.sv
module rs_store #(
  parameter int W     = 21,
  parameter int DEPTH = 31,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;
  logic [W-1:0] fwd_d;
  logic         fwd_q;

  // Simple dual-port array with a registered read, block-RAM shaped.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  // Bypass for a read of the slot written in the same cycle.
  always_ff @(posedge clk) begin
    fwd_q <= we && (waddr == raddr);
    fwd_d <= wdata;
  end

  assign rdata = fwd_q ? fwd_d : rd_q;

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl #(
  parameter int ADDR_W = 21,
  parameter int DEPTH  = 31,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_trap,
  input  logic              push_req,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_req,
  input  logic              sw_pop,
  input  logic              tos_wr,
  input  logic [ADDR_W-1:0] tos_wdata,
  input  logic              clr_ovf,
  input  logic              clr_unf,
  output logic [PTR_W-1:0]  sp_q,
  output logic [PTR_W-1:0]  sp_next,
  output logic              we,
  output logic [PTR_W-1:0]  waddr,
  output logic [ADDR_W-1:0] wdata,
  output logic              ovf_q,
  output logic              unf_q,
  output logic              trap_q
);
  import rs_pkg::*;

  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rs_op_e op;
  logic   ovf_set, unf_set, trap_set;

  always_comb op = pick_op(push_req, pop_req | sw_pop, tos_wr);

  always_comb begin
    sp_next  = sp_q;
    we       = 1'b0;
    waddr    = sp_q;
    wdata    = push_addr;
    ovf_set  = 1'b0;
    unf_set  = 1'b0;
    trap_set = 1'b0;
    case (op)
      OP_PUSH: begin
        if (sp_q != FULL) begin
          we      = 1'b1;
          waddr   = sp_q;
          sp_next = sp_q + 1'b1;
          if (sp_q == LAST) begin
            ovf_set  = 1'b1;
            trap_set = cfg_trap;
          end
        end else begin
          ovf_set  = 1'b1;
          trap_set = cfg_trap;
          if (!cfg_trap) begin
            we    = 1'b1;
            waddr = LAST;
          end
        end
      end
      OP_POP: begin
        if (sp_q != '0) begin
          sp_next = sp_q - 1'b1;
        end else begin
          unf_set  = 1'b1;
          trap_set = cfg_trap;
        end
      end
      OP_WR: begin
        if (sp_q != '0) begin
          we    = 1'b1;
          waddr = sp_q - 1'b1;
          wdata = tos_wdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      sp_q   <= sp_next;
      trap_q <= trap_set;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      if (unf_set)      unf_q <= 1'b1;
      else if (clr_unf) unf_q <= 1'b0;
    end
  end

  // R2: a push below full advances the pointer by one
  a_r2_push_advances: assert property (@(posedge clk) disable iff (rst)
    (push_req && sp_q != FULL) |=> (sp_q == $past(sp_q) + 1'b1));

  // R3: a pop on a non-empty stack with no push lowers the pointer
  a_r3_pop_lowers: assert property (@(posedge clk) disable iff (rst)
    (!push_req && (pop_req || sw_pop) && sp_q != '0) |=> (sp_q == $past(sp_q) - 1'b1));

  // R4: overflow flag is sticky without a clear
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);

  // R5: a push at full never moves the pointer
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (push_req && sp_q == FULL) |=> (sp_q == FULL && ovf_q));

  // R6: traps occur only in trap mode and last one cycle unless retriggered
  a_r6_trap_mode_only: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> cfg_trap);

  // R7: pop on empty keeps the pointer at zero and flags underflow
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (!push_req && (pop_req || sw_pop) && sp_q == '0) |=> (sp_q == '0 && unf_q));

  // R8: a top-entry write alone never moves the pointer
  a_r8_wr_keeps_sp: assert property (@(posedge clk) disable iff (rst)
    (tos_wr && !push_req && !pop_req && !sw_pop) |=> $stable(sp_q));

  // R2: the pointer never passes the stack depth
  always_comb begin
    if (!rst) a_r2_sp_bound: assert (sp_q <= FULL);
  end

endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top #(
  parameter int                 ADDR_W    = 21,
  parameter int                 DEPTH     = 31,
  parameter int                 PTR_W     = $clog2(DEPTH + 1),
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_trap_mode,
  input  logic              push_req,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_req,
  input  logic              sw_pop,
  input  logic              tos_wr,
  input  logic [ADDR_W-1:0] tos_wdata,
  input  logic              clr_ovf,
  input  logic              clr_unf,
  output logic [ADDR_W-1:0] tos_data,
  output logic [PTR_W-1:0]  sp,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              trap_req,
  output logic [ADDR_W-1:0] trap_vec
);

  logic [PTR_W-1:0]  sp_q, sp_next, waddr, raddr;
  logic              we;
  logic [ADDR_W-1:0] wdata, rdata;

  rs_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_trap(cfg_trap_mode),
    .push_req(push_req), .push_addr(push_addr),
    .pop_req(pop_req), .sw_pop(sw_pop),
    .tos_wr(tos_wr), .tos_wdata(tos_wdata),
    .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .sp_q(sp_q), .sp_next(sp_next),
    .we(we), .waddr(waddr), .wdata(wdata),
    .ovf_q(ovf_flag), .unf_q(unf_flag), .trap_q(trap_req)
  );

  // Read the slot that will be on top after this edge.
  assign raddr = (sp_next == '0) ? '0 : sp_next - 1'b1;

  rs_store #(.W(ADDR_W), .DEPTH(DEPTH), .AW(PTR_W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign sp       = sp_q;
  assign tos_data = (sp_q == '0) ? '0 : rdata;
  assign trap_vec = RESET_VEC;

endmodule

// File: tb/ret_stack_top_test.sv
`timescale 1ns/1ps
module ret_stack_top_test;
  localparam int AW = 21;
  localparam int DEPTH = 31;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg = 1'b0;
  logic push_req = 0, pop_req = 0, sw_pop = 0, tos_wr = 0, clr_ovf = 0, clr_unf = 0;
  logic [AW-1:0] push_addr = '0, tos_wdata = '0;
  logic [AW-1:0] tos_data, trap_vec;
  logic [4:0] sp;
  logic ovf_flag, unf_flag, trap_req;

  int ntests = 0, nfail = 0;
  int q[$];
  bit m_ovf, m_unf, m_trap;

  always #2 clk = ~clk;

  ret_stack_top uut (
    .clk(clk), .rst(rst), .cfg_trap_mode(cfg),
    .push_req(push_req), .push_addr(push_addr),
    .pop_req(pop_req), .sw_pop(sw_pop),
    .tos_wr(tos_wr), .tos_wdata(tos_wdata),
    .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .tos_data(tos_data), .sp(sp),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  task automatic chk(string req, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 pointer", int'(sp), q.size());
    chk("R2 top entry", int'(tos_data), (q.size() == 0) ? 0 : q[$]);
    chk("R4 overflow flag", int'(ovf_flag), int'(m_ovf));
    chk("R7 underflow flag", int'(unf_flag), int'(m_unf));
    chk("R6 trap request", int'(trap_req), int'(m_trap));
    chk("R6 trap vector", int'(trap_vec), 0);
  endtask

  // Behavioural reference: one operation per cycle, R10 priority.
  task automatic step(bit pu, int a, bit po, bit sw, bit wr, int d, bit co, bit cu);
    bit os, us;
    push_req = pu; push_addr = AW'(a); pop_req = po; sw_pop = sw;
    tos_wr = wr; tos_wdata = AW'(d); clr_ovf = co; clr_unf = cu;
    @(posedge clk);
    os = 0; us = 0; m_trap = 0;
    if (pu) begin
      if (q.size() < DEPTH) begin
        q.push_back(a & MASK);
        if (q.size() == DEPTH) begin os = 1; m_trap = cfg; end
      end else begin
        os = 1; m_trap = cfg;
        if (!cfg) q[DEPTH-1] = a & MASK;
      end
    end else if (po || sw) begin
      if (q.size() > 0) void'(q.pop_back());
      else begin us = 1; m_trap = cfg; end
    end else if (wr) begin
      if (q.size() > 0) q[q.size()-1] = d & MASK;
    end
    if (os) m_ovf = 1; else if (co) m_ovf = 0;
    if (us) m_unf = 1; else if (cu) m_unf = 0;
    @(negedge clk);
    push_req = 0; pop_req = 0; sw_pop = 0; tos_wr = 0; clr_ovf = 0; clr_unf = 0;
    compare_all();
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst = 1; cfg = mode;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    q.delete(); m_ovf = 0; m_unf = 0; m_trap = 0;
    compare_all(); // R1 reset state
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    // R1
    do_reset(1'b0);
    // R2 fill, R4 flag on the 31st push
    for (int i = 0; i < DEPTH; i++) step(1, 'h1000 + i, 0, 0, 0, 0, 0, 0);
    // R5 flag mode overwrites the top at full
    step(1, 'h1ABCDE, 0, 0, 0, 0, 0, 0);
    step(1, 'h0F0F0, 0, 0, 0, 0, 0, 0);
    // R9 clear together with set: set wins
    step(1, 'h777, 0, 0, 0, 0, 1, 0);
    // R8 top write holds the pointer
    step(0, 0, 0, 0, 1, 'h12345, 0, 0);
    // R9 clear overflow
    step(0, 0, 0, 0, 0, 0, 1, 0);
    // R3 drain by both pop sources
    for (int i = 0; i < DEPTH; i++) step(0, 0, i[0], !i[0], 0, 0, 0, 0);
    // R7 empty pop in flag mode: no trap
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 1); // set beats clear
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // R8 write to empty is ignored
    step(0, 0, 0, 0, 1, 'h55555, 0, 0);
    step(1, 'h42, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R10 push beats pop and write; pop beats write
    step(1, 'h99, 1, 1, 1, 'h11, 0, 0);
    step(0, 0, 1, 0, 1, 'h22, 0, 0);

    // R6 trap mode
    do_reset(1'b1);
    for (int i = 0; i < DEPTH; i++) step(1, 'h2000 + i, 0, 0, 0, 0, 0, 0);
    step(1, 'h1FFFFF, 0, 0, 0, 0, 0, 0); // discarded
    step(0, 0, 0, 0, 0, 0, 0, 0);        // pulse ends
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);        // R7 trap on empty pop
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R10 mixed random traffic in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int i = 0; i < 600; i++) begin
        int r;
        r = $urandom_range(0, 99);
        step(r < 45, $urandom, (r >= 40 && r < 75), (r >= 70 && r < 80),
             (r >= 78), $urandom, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule